// File: doc/BRIEF.md
# UART Interrupt Arbitration and Line Status

This block keeps the status and interrupt state of a serial port. The receive and transmit datapaths send it one-cycle event strobes: a character landed in the receive buffer, a parity, framing or break error was seen, the holding register was loaded, moved into the shift register, or the shift register drained. It holds these as line-status flags. It combines them with a four-bit enable register and a modem-change summary into one interrupt request, and it reports the winning cause in an identification word.

Register accesses reach the block as single-cycle read and write strobes with a shared write-data bus. The three readable words are presented combinationally from the held state. Every side effect of an access, such as clear-on-read or acknowledging a cause, takes effect at the clock edge that ends the access cycle. A host sees the value it reads and then the cleared state from the next cycle on.

Top module: `uart_irq_status`

## Requirements
- R1: After reset the enable word reads 0x00, the line-status word reads 0x60 (both transmit-empty flags set, all others clear), the identification word reads 0x01 and `irq` is low.
- R2: An enable write stores data bits 3:0 as receive-full enable (bit 0), holding-empty enable (bit 1), line-error enable (bit 2) and modem-change enable (bit 3). Bits 7:4 of the enable word always read 0.
- R3: Line-status bit 0 (data ready) sets when a character is loaded. It clears on a receive-buffer read or on a line-status write with bit 0 at 0. A load in the same cycle as a clear leaves the bit set.
- R4: Bit 1 (overrun) sets when a character is loaded while data ready is already 1 and the receive buffer is not read in that same cycle.
- R5: Bits 2, 3 and 4 (parity, framing, break) set on their strobes. A line-status read clears bits 4:1, but an error event in the same cycle still sets its bit. The read leaves bits 0, 5 and 6 unchanged.
- R6: Bit 5 (holding empty) clears on a holding-register load and sets on a transfer to the shift register; the load wins. Bit 6 (shift empty) clears on a transfer and sets on the shift-done strobe; the transfer wins.
- R7: A line-status write sets each of bits 6:0 whose data bit is 1. A 0 in the data has no effect except on bit 0. Bit 7 always reads 0.
- R8: The identification word is {5'b0, cause[1:0], n_pending}. Bit 0 is 0 while an interrupt is pending, and `irq` is high exactly then. Cause codes, highest priority first: 11 line error, 10 receive full, 01 holding empty, 00 modem change.
- R9: The holding-empty cause is armed at reset and whenever bit 5 goes from 0 to 1. It is disarmed by a holding-register load, or by an identification read that reports code 01.
- R10: An identification read that reports code 11, 10 or 00 freezes that code. Later words show it even if a higher cause appears, until its condition clears. The next highest active cause is then shown.
- R11: A cause counts only while its enable bit is 1. With all enables 0, `irq` is low whatever the flags hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_load | input | 1 | Character moved into the receive buffer |
| rx_pe | input | 1 | Parity error seen |
| rx_fe | input | 1 | Framing error seen |
| rx_bi | input | 1 | Break condition seen |
| tx_hold_wr | input | 1 | Host wrote the transmit holding register |
| tx_xfer | input | 1 | Holding register moved into the shift register |
| tx_idle | input | 1 | Shift register finished sending |
| modem_delta | input | 1 | Level: some modem-line change flag is set |
| ier_wr | input | 1 | Enable-word write strobe |
| iir_rd | input | 1 | Identification-word read strobe |
| lsr_rd | input | 1 | Line-status read strobe |
| lsr_wr | input | 1 | Line-status write strobe |
| rbr_rd | input | 1 | Receive-buffer read strobe |
| wdata | input | 8 | Write data for enable and line-status writes |
| ier_q | output | 8 | Enable word |
| iir_q | output | 8 | Identification word |
| lsr_q | output | 8 | Line-status word |
| irq | output | 1 | Interrupt request, active high |

## Verification
Every flag and enable bit is a single register. A strobe held for one cycle therefore shows on the outputs right after the next rising edge, one cycle later, and the identification word and `irq` follow combinationally in that same cycle. The bench drives each stimulus just after a rising edge and compares all outputs just after the following edge. Each comparison thus falls in the first cycle where the result is due and before any later stimulus can change it. Directed sequences pin down the priority, freeze, same-cycle collision and write-one-to-set cases. A long seeded random run is then compared every cycle against a bench model of the requirements.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int REG_W  = 8;   // width of every host-visible word
  localparam int EN_N   = 4;   // number of interrupt causes / enable bits
  localparam int ERR_N  = 4;   // overrun, parity, framing, break
  localparam int LSR_W  = 7;   // writable line-status bits
  localparam int CODE_W = $clog2(EN_N);

  // line-status bit positions
  localparam int LSR_DR   = 0;
  localparam int LSR_OE   = 1;
  localparam int LSR_THRE = LSR_OE + ERR_N;
  localparam int LSR_TSRE = LSR_THRE + 1;

  // enable bit positions
  localparam int IE_RBF = 0;
  localparam int IE_THR = 1;
  localparam int IE_RLS = 2;
  localparam int IE_MDM = 3;

  // cause codes, numerically ordered by priority
  typedef enum logic [CODE_W-1:0] {
    CAUSE_MDM = 2'b00,
    CAUSE_THR = 2'b01,
    CAUSE_RBF = 2'b10,
    CAUSE_RLS = 2'b11
  } cause_e;

  // act is indexed by cause code; the highest set index wins
  function automatic cause_e pick_cause(input logic [EN_N-1:0] act);
    cause_e c;
    c = CAUSE_MDM;
    for (int i = 0; i < EN_N; i++)
      if (act[i]) c = cause_e'(i[CODE_W-1:0]);
    return c;
  endfunction

  function automatic logic [REG_W-1:0] iir_word(input logic pend, input cause_e id);
    return {{(REG_W-CODE_W-1){1'b0}}, id, ~pend};
  endfunction
endpackage

// File: rtl/uart_ier_reg.sv
module uart_ier_reg
  import uart_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ier_wr,
  input  logic [EN_N-1:0] wbits,
  output logic [EN_N-1:0] en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en <= '0;
    else if (ier_wr) en <= wbits;
  end

  a_r2_ier_store: assert property (@(posedge clk) disable iff (!rst_n)
    ier_wr |=> en == $past(wbits));
  a_r2_ier_keep: assert property (@(posedge clk) disable iff (!rst_n)
    !ier_wr |=> $stable(en));
endmodule

// File: rtl/uart_lsr_flags.sv
module uart_lsr_flags
  import uart_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_load,
  input  logic             rx_pe,
  input  logic             rx_fe,
  input  logic             rx_bi,
  input  logic             rbr_rd,
  input  logic             lsr_rd,
  input  logic             lsr_wr,
  input  logic [LSR_W-1:0] wbits,
  input  logic             tx_hold_wr,
  input  logic             tx_xfer,
  input  logic             tx_idle,
  input  logic             thr_ack,
  output logic [REG_W-1:0] lsr_q,
  output logic             err_any,
  output logic             dr,
  output logic             thr_pend
);
  logic             dr_q, thre_q, tsre_q, thp_q;
  logic [ERR_N-1:0] err_q, err_d, err_ev;
  logic [LSR_W-1:0] wset;

  // named internal events
  logic overrun_ev, dr_set, dr_clr, thre_rise;
  logic dr_d, thre_d, tsre_d, thp_d;

  assign wset       = lsr_wr ? wbits : '0;
  assign overrun_ev = rx_load & dr_q & ~rbr_rd;
  assign dr_set     = rx_load | wset[LSR_DR];
  assign dr_clr     = rbr_rd | (lsr_wr & ~wbits[LSR_DR]);
  assign dr_d       = dr_set | (dr_q & ~dr_clr);
  assign err_ev     = {rx_bi, rx_fe, rx_pe, overrun_ev};

  for (genvar j = 0; j < ERR_N; j++) begin : g_err
    assign err_d[j] = err_ev[j] | wset[LSR_OE+j] | (err_q[j] & ~lsr_rd);
  end

  assign thre_d    = wset[LSR_THRE] | (~tx_hold_wr & (tx_xfer | thre_q));
  assign tsre_d    = wset[LSR_TSRE] | (~tx_xfer & (tx_idle | tsre_q));
  assign thre_rise = thre_d & ~thre_q;
  assign thp_d     = thre_rise | (thp_q & ~tx_hold_wr & ~thr_ack);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dr_q   <= 1'b0;
      err_q  <= '0;
      thre_q <= 1'b1;
      tsre_q <= 1'b1;
      thp_q  <= 1'b1;
    end else begin
      dr_q   <= dr_d;
      err_q  <= err_d;
      thre_q <= thre_d;
      tsre_q <= tsre_d;
      thp_q  <= thp_d;
    end
  end

  assign lsr_q    = {{(REG_W-LSR_W){1'b0}}, tsre_q, thre_q, err_q, dr_q};
  assign err_any  = |err_q;
  assign dr       = dr_q;
  assign thr_pend = thp_q;

  a_r4_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_load && dr && !rbr_rd) |=> lsr_q[LSR_OE]);
  a_r3_buf_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rbr_rd && !rx_load && !(lsr_wr && wbits[LSR_DR])) |=> !lsr_q[LSR_DR]);
  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !lsr_wr && !rx_pe && !rx_fe && !rx_bi && !(rx_load && dr)) |=> !err_any);
  a_r6_hold_load: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_hold_wr && !(lsr_wr && wbits[LSR_THRE])) |=> !lsr_q[LSR_THRE] && !thr_pend);
  a_r9_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_ack && lsr_q[LSR_THRE]) |=> !thr_pend);
endmodule

// File: rtl/uart_irq_arbiter.sv
module uart_irq_arbiter
  import uart_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EN_N-1:0]  en,
  input  logic             err_any,
  input  logic             dr,
  input  logic             thr_pend,
  input  logic             modem_delta,
  input  logic             iir_rd,
  output logic [REG_W-1:0] iir_q,
  output logic             irq,
  output logic             thr_ack
);
  logic [EN_N-1:0] act;
  logic   frz_q, frz_live, pend, frz_take;
  cause_e frz_id, rep_id;

  assign act[CAUSE_RLS] = en[IE_RLS] & err_any;
  assign act[CAUSE_RBF] = en[IE_RBF] & dr;
  assign act[CAUSE_THR] = en[IE_THR] & thr_pend;
  assign act[CAUSE_MDM] = en[IE_MDM] & modem_delta;

  assign frz_live = frz_q & act[frz_id];
  assign rep_id   = frz_live ? frz_id : pick_cause(act);
  assign pend     = frz_live | (|act);
  assign thr_ack  = iir_rd & pend & (rep_id == CAUSE_THR);
  assign frz_take = iir_rd & pend & (rep_id != CAUSE_THR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frz_q  <= 1'b0;
      frz_id <= CAUSE_MDM;
    end else if (frz_take) begin
      frz_q  <= 1'b1;
      frz_id <= rep_id;
    end else if (frz_q && !act[frz_id]) begin
      frz_q  <= 1'b0;
    end
  end

  assign iir_q = iir_word(pend, rep_id);
  assign irq   = pend;

  a_r10_frozen_shown: assert property (@(posedge clk) disable iff (!rst_n)
    (frz_q && act[frz_id]) |-> (iir_q[CODE_W:1] == frz_id) && !iir_q[0]);
  a_r11_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> !irq);
  a_r8_top_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (!frz_q && act[CAUSE_RLS]) |-> iir_q[CODE_W:1] == CAUSE_RLS);
endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
  import uart_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_load,
  input  logic             rx_pe,
  input  logic             rx_fe,
  input  logic             rx_bi,
  input  logic             tx_hold_wr,
  input  logic             tx_xfer,
  input  logic             tx_idle,
  input  logic             modem_delta,
  input  logic             ier_wr,
  input  logic             iir_rd,
  input  logic             lsr_rd,
  input  logic             lsr_wr,
  input  logic             rbr_rd,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] ier_q,
  output logic [REG_W-1:0] iir_q,
  output logic [REG_W-1:0] lsr_q,
  output logic             irq
);
  logic [EN_N-1:0] en;
  logic err_any, dr, thr_pend, thr_ack;
  logic unused_wdata_top;

  assign unused_wdata_top = ^wdata[REG_W-1:LSR_W];

  uart_ier_reg u_ier (
    .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr),
    .wbits(wdata[EN_N-1:0]), .en(en)
  );

  uart_lsr_flags u_lsr (
    .clk(clk), .rst_n(rst_n),
    .rx_load(rx_load), .rx_pe(rx_pe), .rx_fe(rx_fe), .rx_bi(rx_bi),
    .rbr_rd(rbr_rd), .lsr_rd(lsr_rd), .lsr_wr(lsr_wr),
    .wbits(wdata[LSR_W-1:0]),
    .tx_hold_wr(tx_hold_wr), .tx_xfer(tx_xfer), .tx_idle(tx_idle),
    .thr_ack(thr_ack), .lsr_q(lsr_q), .err_any(err_any),
    .dr(dr), .thr_pend(thr_pend)
  );

  uart_irq_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .en(en), .err_any(err_any), .dr(dr),
    .thr_pend(thr_pend), .modem_delta(modem_delta), .iir_rd(iir_rd),
    .iir_q(iir_q), .irq(irq), .thr_ack(thr_ack)
  );

  assign ier_q = {{(REG_W-EN_N){1'b0}}, en};
endmodule

// File: tb/uart_irq_status_test.sv
`timescale 1ns/1ps
module uart_irq_status_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_load = 0, rx_pe = 0, rx_fe = 0, rx_bi = 0;
  logic tx_hold_wr = 0, tx_xfer = 0, tx_idle = 0, modem_delta = 0;
  logic ier_wr = 0, iir_rd = 0, lsr_rd = 0, lsr_wr = 0, rbr_rd = 0;
  logic [7:0] wdata = 0;
  logic [7:0] ier_q, iir_q, lsr_q;
  logic irq;
  int n_tot = 0, n_ok = 0, cycles = 0;

  // bench model state
  bit [3:0] m_en;
  bit m_dr, m_oe, m_pe, m_fe, m_bi, m_thre, m_tsre, m_thp, m_frz;
  bit [1:0] m_fid;

  always #5 clk = ~clk;

  uart_irq_status uut (
    .clk(clk), .rst_n(rst_n), .rx_load(rx_load), .rx_pe(rx_pe), .rx_fe(rx_fe),
    .rx_bi(rx_bi), .tx_hold_wr(tx_hold_wr), .tx_xfer(tx_xfer), .tx_idle(tx_idle),
    .modem_delta(modem_delta), .ier_wr(ier_wr), .iir_rd(iir_rd), .lsr_rd(lsr_rd),
    .lsr_wr(lsr_wr), .rbr_rd(rbr_rd), .wdata(wdata), .ier_q(ier_q),
    .iir_q(iir_q), .lsr_q(lsr_q), .irq(irq)
  );

  // active causes indexed by code: 3 line error, 2 rx full, 1 tx empty, 0 modem
  function automatic bit [3:0] f_act();
    return {m_en[2] & (m_oe | m_pe | m_fe | m_bi), m_en[0] & m_dr,
            m_en[1] & m_thp, m_en[3] & modem_delta};
  endfunction

  function automatic bit [2:0] f_report(); // {pending, code}
    bit [3:0] a = f_act();
    if (m_frz && a[m_fid]) return {1'b1, m_fid};
    if (a[3]) return 3'b111;
    if (a[2]) return 3'b110;
    if (a[1]) return 3'b101;
    if (a[0]) return 3'b100;
    return 3'b000;
  endfunction

  function automatic bit [7:0] f_lsr();
    return {1'b0, m_tsre, m_thre, m_bi, m_fe, m_pe, m_oe, m_dr};
  endfunction

  function automatic bit [7:0] f_iir();
    bit [2:0] r = f_report();
    return {5'b0, r[1:0], ~r[2]};
  endfunction

  task automatic model_step();
    bit [2:0] r = f_report();
    bit [3:0] a = f_act();
    bit [7:0] w = lsr_wr ? wdata : 8'h00;
    bit nthre;
    bit ack = iir_rd && r[2] && r[1:0] == 2'b01;
    bit take = iir_rd && r[2] && r[1:0] != 2'b01;
    bit ov = rx_load && m_dr && !rbr_rd;
    m_oe = ov | w[1] | (m_oe & !lsr_rd);
    m_pe = rx_pe | w[2] | (m_pe & !lsr_rd);
    m_fe = rx_fe | w[3] | (m_fe & !lsr_rd);
    m_bi = rx_bi | w[4] | (m_bi & !lsr_rd);
    m_dr = rx_load | w[0] | (m_dr & !rbr_rd & !(lsr_wr && !wdata[0]));
    nthre = w[5] | (!tx_hold_wr & (tx_xfer | m_thre));
    m_thp = (nthre & !m_thre) | (m_thp & !tx_hold_wr & !ack);
    m_thre = nthre;
    m_tsre = w[6] | (!tx_xfer & (tx_idle | m_tsre));
    if (take) begin m_frz = 1; m_fid = r[1:0]; end
    else if (m_frz && !a[m_fid]) m_frz = 0;
    if (ier_wr) m_en = wdata[3:0];
  endtask

  task automatic chk(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
    n_tot++;
    if (got === exp) n_ok++;
    else $display("FAIL %s %s: got %02h expected %02h", req, what, got, exp);
  endtask

  // apply the strobes currently set, advance one edge, clear the strobes
  task automatic tick();
    model_step();
    @(posedge clk); #1;
    cycles++;
    {rx_load, rx_pe, rx_fe, rx_bi, tx_hold_wr, tx_xfer, tx_idle} = '0;
    {ier_wr, iir_rd, lsr_rd, lsr_wr, rbr_rd} = '0;
  endtask

  task automatic expect3(input string req, input logic [7:0] e_ier, input logic [7:0] e_lsr, input logic [7:0] e_iir);
    chk(req, "ier", ier_q, e_ier);
    chk(req, "lsr", lsr_q, e_lsr);
    chk(req, "iir", iir_q, e_iir);
    chk(req, "irq", {7'b0, irq}, {7'b0, ~e_iir[0]});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_tot++;
    $display("FAIL watchdog expired: got timeout expected completion");
    $display("%0d/%0d checks passed", n_ok, n_tot);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h1c3a5e77));
    m_en = 0; m_dr = 0; m_oe = 0; m_pe = 0; m_fe = 0; m_bi = 0;
    m_thre = 1; m_tsre = 1; m_thp = 1; m_frz = 0; m_fid = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    expect3("R1", 8'h00, 8'h60, 8'h01);

    // R2: enable write, upper bits dropped; armed tx-empty cause shows (R9)
    ier_wr = 1; wdata = 8'hFF; tick();
    expect3("R2", 8'h0F, 8'h60, 8'h02);
    iir_rd = 1; tick();
    expect3("R9", 8'h0F, 8'h60, 8'h01);

    // R3 data ready, R4 overrun, R8 priority
    rx_load = 1; tick();
    expect3("R3", 8'h0F, 8'h61, 8'h04);
    rx_load = 1; tick();
    expect3("R4", 8'h0F, 8'h63, 8'h06);
    lsr_rd = 1; tick();
    expect3("R5", 8'h0F, 8'h61, 8'h04);

    // R10: freeze receive-full, then a higher cause appears
    iir_rd = 1; tick();
    rx_pe = 1; tick();
    expect3("R10", 8'h0F, 8'h65, 8'h04);
    rbr_rd = 1; tick();
    expect3("R10", 8'h0F, 8'h64, 8'h06);
    lsr_rd = 1; tick();
    expect3("R5", 8'h0F, 8'h60, 8'h01);

    // R6 / R9 transmit flags
    tx_hold_wr = 1; tick();
    expect3("R6", 8'h0F, 8'h40, 8'h01);
    tx_xfer = 1; tick();
    expect3("R9", 8'h0F, 8'h20, 8'h02);
    tx_idle = 1; tick();
    expect3("R6", 8'h0F, 8'h60, 8'h02);
    tx_hold_wr = 1; tick();
    expect3("R9", 8'h0F, 8'h40, 8'h01);
    tx_xfer = 1; tick();
    tx_idle = 1; tick();
    expect3("R6", 8'h0F, 8'h60, 8'h02);

    // R11 enable gating
    ier_wr = 1; wdata = 8'h00; tick();
    expect3("R11", 8'h00, 8'h60, 8'h01);
    modem_delta = 1; ier_wr = 1; wdata = 8'h08; tick();
    expect3("R11", 8'h08, 8'h60, 8'h00);
    ier_wr = 1; wdata = 8'h0A; tick();
    expect3("R8", 8'h0A, 8'h60, 8'h02);
    iir_rd = 1; tick();
    modem_delta = 0; ier_wr = 1; wdata = 8'h00; tick();
    expect3("R11", 8'h00, 8'h60, 8'h01);

    // R7 write-one-to-set
    lsr_wr = 1; wdata = 8'h7F; tick();
    expect3("R7", 8'h00, 8'h7F, 8'h01);
    lsr_wr = 1; wdata = 8'h00; tick();
    expect3("R7", 8'h00, 8'h7E, 8'h01);
    lsr_rd = 1; tick();
    expect3("R5", 8'h00, 8'h60, 8'h01);
    lsr_wr = 1; wdata = 8'h80; tick();
    expect3("R7", 8'h00, 8'h60, 8'h01);

    // same-cycle collisions
    rx_load = 1; rbr_rd = 1; tick();
    expect3("R3", 8'h00, 8'h61, 8'h01);
    rx_load = 1; rbr_rd = 1; tick();
    expect3("R4", 8'h00, 8'h61, 8'h01);
    rbr_rd = 1; tick();
    lsr_rd = 1; rx_fe = 1; tick();
    expect3("R5", 8'h00, 8'h68, 8'h01);
    lsr_rd = 1; tick();
    expect3("R5", 8'h00, 8'h60, 8'h01);

    // seeded random run against the bench model
    for (int k = 0; k < 3000; k++) begin
      rx_load    = ($urandom % 6) == 0;
      rx_pe      = ($urandom % 15) == 0;
      rx_fe      = ($urandom % 15) == 0;
      rx_bi      = ($urandom % 20) == 0;
      tx_hold_wr = ($urandom % 6) == 0;
      tx_xfer    = ($urandom % 6) == 0;
      tx_idle    = ($urandom % 5) == 0;
      iir_rd     = ($urandom % 4) == 0;
      lsr_rd     = ($urandom % 8) == 0;
      rbr_rd     = ($urandom % 5) == 0;
      ier_wr     = ($urandom % 20) == 0;
      lsr_wr     = ($urandom % 30) == 0;
      wdata      = 8'($urandom);
      if (($urandom % 10) == 0) modem_delta = ~modem_delta;
      tick();
      chk("R3-model", "lsr", lsr_q, f_lsr());
      chk("R8-model", "iir", iir_q, f_iir());
      chk("R2-model", "ier", ier_q, {4'b0, m_en});
      chk("R10-model", "irq", {7'b0, irq}, {7'b0, ~f_iir()[0]});
    end

    $display("%0d/%0d checks passed", n_ok, n_tot);
    $finish;
  end
endmodule